// File: doc/BRIEF.md
# Transfer Core Run-State Controller

This block sequences the operating state of a serial transfer core under register control. Software writes a two-bit code to request RESET, RUN or PAUSE. A VALID status flag goes low while the request settles, and rises again once the new state is in force. The data path is driven through plain enable and clear outputs. Counters and FIFOs get a one-cycle clear strobe whenever the core enters RESET. Shifting is enabled only while RUN is in force and settled. A hold output is raised while the core sits in PAUSE.

A direction configuration word holds a no-input flag and a no-output flag, and the block exposes them as input-enable and output-enable. This word can only be loaded while the core is settled in RESET, so the intended use is: load the configuration in RESET, move to RUN, and return to RESET to end the transfer. A separate soft-reset register returns the whole block to its reset condition in a single cycle.

Top module: `xfer_runstate_ctrl`

## Requirements
- R1: After the synchronous reset, the core is in RESET with VALID set and both directions enabled. The clear, shift and hold outputs are low, and the configuration word reads zero.
- R2: The state register is at word address 0. Reading it returns the state in force in bits [1:0], with RESET=0, RUN=1 and PAUSE=3, and VALID in bit 2. All other bits read zero.
- R3: A state write with code 0, 1 or 3 is accepted when VALID is high. VALID then reads low for exactly 2 cycles after the write edge and is high again from the next edge. While VALID is low the readback shows the old state; once VALID is high it shows the new state.
- R4: A state write with code 2 is ignored. The state and VALID are left unchanged.
- R5: A state write made while VALID is low is ignored. The settling request completes to its own code.
- R6: When a request for RESET settles (including a RESET request made while already in RESET), the clear output is high for exactly one cycle: the first cycle in which VALID is high again. Requests for RUN or PAUSE never raise it.
- R7: Writing a word with bit 0 set to word address 2 returns the core to RESET with VALID high on the next edge. The same edge clears the configuration word and aborts any settling request, and the clear output is raised for one cycle. A write there with bit 0 clear has no effect.
- R8: The configuration word is at word address 1, with no-input at bit 7 and no-output at bit 6. Input-enable is the inverse of bit 7 and output-enable is the inverse of bit 6. Only these two bits read back; all other bits read zero.
- R9: A configuration write takes effect only while the core is in RESET with VALID high. In any other condition it is ignored.
- R10: The shift enable is high exactly when RUN is in force and VALID is high. The hold output is high exactly while PAUSE is the state in force.
- R11: Word addresses 2 and 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read word address |
| rd_data | output | DATA_W | Register read data (combinational) |
| dp_clear | output | 1 | One-cycle clear strobe to counters and FIFOs |
| dp_shift_en | output | 1 | Shifting allowed |
| dp_hold | output | 1 | Data path holds (PAUSE) |
| in_en | output | 1 | Input direction enabled |
| out_en | output | 1 | Output direction enabled |

## Verification
The bench builds the block with its defaults: a settle time of 2 cycles, 16-bit data and 2-bit addresses. With these values every transition takes only a few cycles, so the bench can sweep every pair of starting state and written code, including the rejected code 2, and check each cycle of the settle window. It also sweeps all four direction settings, tries configuration writes in every state and mid-transition, issues back-to-back state writes, and applies the soft reset both in a settled state and during settling.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

    typedef enum logic [1:0] {
        CORE_RESET = 2'd0,
        CORE_RUN   = 2'd1,
        CORE_CLEAR = 2'd2,
        CORE_PAUSE = 2'd3
    } core_state_e;

    localparam int REG_STATE = 0;
    localparam int REG_CFG   = 1;
    localparam int REG_SWRST = 2;

    localparam int VALID_BIT = 2;
    localparam int NOIN_BIT  = 7;
    localparam int NOOUT_BIT = 6;

    typedef struct packed {
        logic        state_wr;
        core_state_e state_code;
        logic        cfg_wr;
        logic        no_in;
        logic        no_out;
        logic        sw_reset;
    } wr_req_t;

    typedef struct packed {
        logic no_in;
        logic no_out;
    } dir_cfg_t;

    function automatic logic code_accepted(core_state_e c);
        return c != CORE_CLEAR;
    endfunction

endpackage

// File: rtl/xrs_decode.sv
module xrs_decode
    import xrs_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wr_req_t           req
);

    logic unused_data;
    assign unused_data = ^{wr_data[DATA_W-1:8], wr_data[5:2]};

    always_comb begin
        req            = '0;
        req.state_code = core_state_e'(wr_data[1:0]);
        req.no_in      = wr_data[NOIN_BIT];
        req.no_out     = wr_data[NOOUT_BIT];
        req.state_wr   = wr_en && (wr_addr == ADDR_W'(REG_STATE));
        req.cfg_wr     = wr_en && (wr_addr == ADDR_W'(REG_CFG));
        req.sw_reset   = wr_en && (wr_addr == ADDR_W'(REG_SWRST)) && wr_data[0];
    end

endmodule

// File: rtl/xrs_seq.sv
module xrs_seq
    import xrs_pkg::*;
#(
    parameter int SETTLE = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  wr_req_t     req,
    output core_state_e cur_state,
    output logic        st_valid,
    output logic        clr_pulse
);

    localparam int CNT_W = (SETTLE < 2) ? 1 : $clog2(SETTLE + 1);

    core_state_e      pend;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_state <= CORE_RESET;
            pend      <= CORE_RESET;
            st_valid  <= 1'b1;
            cnt       <= '0;
            clr_pulse <= 1'b0;
        end else if (req.sw_reset) begin
            cur_state <= CORE_RESET;
            pend      <= CORE_RESET;
            st_valid  <= 1'b1;
            cnt       <= '0;
            clr_pulse <= 1'b1;
        end else begin
            clr_pulse <= 1'b0;
            if (!st_valid) begin
                if (cnt == CNT_W'(1)) begin
                    cur_state <= pend;
                    st_valid  <= 1'b1;
                    cnt       <= '0;
                    clr_pulse <= (pend == CORE_RESET);
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (req.state_wr && code_accepted(req.state_code)) begin
                pend     <= req.state_code;
                st_valid <= 1'b0;
                cnt      <= CNT_W'(SETTLE);
            end
        end
    end

endmodule

// File: rtl/xrs_cfg.sv
module xrs_cfg
    import xrs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  wr_req_t     req,
    input  core_state_e cur_state,
    input  logic        st_valid,
    output dir_cfg_t    cfg
);

    logic load_ok;
    assign load_ok = req.cfg_wr && (cur_state == CORE_RESET) && st_valid;

    always_ff @(posedge clk) begin
        if (rst || req.sw_reset) begin
            cfg <= '0;
        end else if (load_ok) begin
            cfg.no_in  <= req.no_in;
            cfg.no_out <= req.no_out;
        end
    end

endmodule

// File: rtl/xfer_runstate_ctrl.sv
module xfer_runstate_ctrl
    import xrs_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16,
    parameter int SETTLE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              dp_clear,
    output logic              dp_shift_en,
    output logic              dp_hold,
    output logic              in_en,
    output logic              out_en
);

    wr_req_t     req;
    core_state_e cur_state;
    logic        st_valid;
    dir_cfg_t    cfg;

    xrs_decode #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_decode (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .req    (req)
    );

    xrs_seq #(
        .SETTLE(SETTLE)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .cur_state(cur_state),
        .st_valid (st_valid),
        .clr_pulse(dp_clear)
    );

    xrs_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .cur_state(cur_state),
        .st_valid (st_valid),
        .cfg      (cfg)
    );

    assign dp_shift_en = (cur_state == CORE_RUN) && st_valid;
    assign dp_hold     = (cur_state == CORE_PAUSE);
    assign in_en       = !cfg.no_in;
    assign out_en      = !cfg.no_out;

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(REG_STATE)) begin
            rd_data[1:0]      = cur_state;
            rd_data[VALID_BIT] = st_valid;
        end else if (rd_addr == ADDR_W'(REG_CFG)) begin
            rd_data[NOIN_BIT]  = cfg.no_in;
            rd_data[NOOUT_BIT] = cfg.no_out;
        end
    end

endmodule

// File: rtl/xrs_checker.sv
module xrs_checker #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [1:0]        cur_state,
    input logic              st_valid,
    input logic              dp_clear,
    input logic              in_en,
    input logic              out_en
);

    logic st_wr, cfg_wr, sw_wr;
    assign st_wr  = wr_en && (wr_addr == ADDR_W'(0));
    assign cfg_wr = wr_en && (wr_addr == ADDR_W'(1));
    assign sw_wr  = wr_en && (wr_addr == ADDR_W'(2)) && wr_data[0];

    // R3
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (st_wr && st_valid && wr_data[1:0] != 2'd2) |=> !st_valid);

    // R4
    clear_code_chk: assert property (@(posedge clk) disable iff (rst)
        (st_wr && st_valid && wr_data[1:0] == 2'd2) |=> (st_valid && $stable(cur_state)));

    // R5
    settle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!st_valid && !sw_wr) |=> (st_valid || $stable(cur_state)));

    // R6
    clear_once_chk: assert property (@(posedge clk) disable iff (rst)
        (dp_clear && !sw_wr) |=> !dp_clear);

    // R7
    soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
        sw_wr |=> (cur_state == 2'd0 && st_valid && dp_clear));

    // R9
    cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !(cur_state == 2'd0 && st_valid) && !sw_wr) |=> ($stable(in_en) && $stable(out_en)));

endmodule

bind xfer_runstate_ctrl xrs_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cur_state(cur_state),
    .st_valid (st_valid),
    .dp_clear (dp_clear),
    .in_en    (in_en),
    .out_en   (out_en)
);

// File: tb/xfer_runstate_ctrl_tb.sv
module xfer_runstate_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              dp_clear, dp_shift_en, dp_hold, in_en, out_en;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xfer_runstate_ctrl #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .SETTLE(2)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .dp_clear   (dp_clear),
        .dp_shift_en(dp_shift_en),
        .dp_hold    (dp_hold),
        .in_en      (in_en),
        .out_en     (out_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the write edge
    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic read_reg(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
        rd_addr = '0;
        #1;
    endtask

    task automatic goto_state(input int s);
        bus_write(2'd0, DATA_W'(s));
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] st_word(input int s, input logic v);
        return 32'(s) | (32'(v) << 2);
    endfunction

    initial begin
        logic [DATA_W-1:0] rv;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        read_reg(2'd0, rv);
        check("R1 state word", 32'(rv), st_word(0, 1'b1));
        read_reg(2'd1, rv);
        check("R1 cfg word", 32'(rv), 32'h0);
        check("R1 in_en/out_en", {30'b0, in_en, out_en}, 32'h3);
        check("R1 clear/shift/hold", {29'b0, dp_clear, dp_shift_en, dp_hold}, 32'h0);

        // R3 R4 R6 R10 sweep over every start state and code
        for (int f = 0; f < 4; f++) begin
            if (f == 2) continue;
            for (int c = 0; c < 4; c++) begin
                goto_state(f);
                bus_write(2'd0, DATA_W'(c) | 16'hFFF8);
                if (c == 2) begin
                    check($sformatf("R4 code2 from %0d", f), 32'(rd_data), st_word(f, 1'b1));
                    check("R4 no clear", 32'(dp_clear), 32'h0);
                    @(negedge clk);
                    check($sformatf("R4 code2 later from %0d", f), 32'(rd_data), st_word(f, 1'b1));
                    continue;
                end
                check($sformatf("R3 settle1 %0d->%0d", f, c), 32'(rd_data), st_word(f, 1'b0));
                check("R10 shift low in settle", 32'(dp_shift_en), 32'h0);
                check("R10 hold in settle", 32'(dp_hold), 32'(f == 3));
                check("R6 no clear settle1", 32'(dp_clear), 32'h0);
                @(negedge clk);
                check($sformatf("R3 settle2 %0d->%0d", f, c), 32'(rd_data), st_word(f, 1'b0));
                check("R6 no clear settle2", 32'(dp_clear), 32'h0);
                @(negedge clk);
                check($sformatf("R3 done %0d->%0d", f, c), 32'(rd_data), st_word(c, 1'b1));
                check($sformatf("R6 clear %0d->%0d", f, c), 32'(dp_clear), 32'(c == 0));
                check("R10 shift", 32'(dp_shift_en), 32'(c == 1));
                check("R10 hold", 32'(dp_hold), 32'(c == 3));
                @(negedge clk);
                check("R6 clear drops", 32'(dp_clear), 32'h0);
            end
        end

        // R5 write during settling ignored
        goto_state(1);
        bus_write(2'd0, 16'd3);
        bus_write(2'd0, 16'd0);
        check("R5 still settling", 32'(rd_data), st_word(1, 1'b0));
        @(negedge clk);
        check("R5 first request wins", 32'(rd_data), st_word(3, 1'b1));
        check("R5 no clear", 32'(dp_clear), 32'h0);
        @(negedge clk);
        check("R5 stays", 32'(rd_data), st_word(3, 1'b1));

        // R8 direction sweep in RESET
        goto_state(0);
        for (int v = 0; v < 4; v++) begin
            bus_write(2'd1, (16'hFF3F) | (DATA_W'(v) << 6));
            read_reg(2'd1, rv);
            check($sformatf("R8 cfg read %0d", v), 32'(rv), 32'(v) << 6);
            check($sformatf("R8 in_en %0d", v), 32'(in_en), 32'(!v[1]));
            check($sformatf("R8 out_en %0d", v), 32'(out_en), 32'(!v[0]));
        end
        bus_write(2'd1, 16'h0000);

        // R9 config ignored outside settled RESET
        goto_state(1);
        bus_write(2'd1, 16'h00C0);
        check("R9 RUN ignored", {30'b0, in_en, out_en}, 32'h3);
        goto_state(3);
        bus_write(2'd1, 16'h00C0);
        check("R9 PAUSE ignored", {30'b0, in_en, out_en}, 32'h3);
        bus_write(2'd0, 16'd0);
        bus_write(2'd1, 16'h00C0);
        check("R9 settling ignored", {30'b0, in_en, out_en}, 32'h3);
        @(negedge clk);
        bus_write(2'd1, 16'h0080);
        read_reg(2'd1, rv);
        check("R9 RESET accepted", 32'(rv), 32'h80);
        check("R9 RESET dirs", {30'b0, in_en, out_en}, 32'h1);

        // R7 soft reset from RUN
        goto_state(1);
        bus_write(2'd2, 16'hFFFE);
        check("R7 bit0 clear ignored", 32'(rd_data), st_word(1, 1'b1));
        check("R7 bit0 clear no strobe", 32'(dp_clear), 32'h0);
        bus_write(2'd2, 16'h0001);
        check("R7 state", 32'(rd_data), st_word(0, 1'b1));
        check("R7 clear", 32'(dp_clear), 32'h1);
        check("R7 cfg cleared", {30'b0, in_en, out_en}, 32'h3);
        @(negedge clk);
        check("R7 clear drops", 32'(dp_clear), 32'h0);

        // R7 soft reset aborts a settling request
        bus_write(2'd0, 16'd1);
        bus_write(2'd2, 16'h0001);
        check("R7 abort state", 32'(rd_data), st_word(0, 1'b1));
        @(negedge clk);
        @(negedge clk);
        check("R7 abort holds", 32'(rd_data), st_word(0, 1'b1));
        check("R7 abort no shift", 32'(dp_shift_en), 32'h0);

        // R11 unused addresses
        read_reg(2'd2, rv);
        check("R11 addr2", 32'(rv), 32'h0);
        read_reg(2'd3, rv);
        check("R11 addr3", 32'(rv), 32'h0);

        // R2 upper bits of state word
        goto_state(3);
        read_reg(2'd0, rv);
        check("R2 state word", 32'(rv), 32'h7);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule